// File: doc/BRIEF.md
# IR Carrier Frequency Meter

This block watches an infrared input that still carries its carrier (not yet demodulated) and measures one full carrier cycle at a time. Time is counted in pulses of a 2 MHz tick, so one count equals 500 ns. The period runs from one rising edge of the input to the next. The high time is the stretch from a rising edge to the falling edge that follows it.

Results sit in two byte-wide registers behind a small read port. Address 0 returns the period: bit 7 is a valid flag and bits 6:0 hold the count. Address 1 returns the high time: bits 6:0 hold the count and bit 7 flags saturation. From these, software derives the carrier frequency (2 MHz divided by the period count) and the duty cycle (high count divided by period count). Measurement runs only while the detect enable is set and the raw-signal input mode is selected.

Top module: `ircm_meter`

## Requirements
- R1: After reset, a read of address 0 and a read of address 1 both return 0x00.
- R2: The input passes a two-flop synchronizer. Each rising edge after the first ends a measured cycle. Three clocks after that input edge, address 0 holds valid=1 (bit 7) and, in bits 6:0, the number of tick pulses counted since the previous rising edge.
- R3: Three clocks after a falling edge that follows a counted rising edge, address 1 holds, in bits 6:0, the number of tick pulses seen during the high phase. Bit 7 is 0 when the count fits.
- R4: The first rising edge after reset, or after measurement is re-enabled, only starts a cycle: the period register is left unchanged.
- R5: If a period count would exceed 127, the period register takes 127 with valid=0. If a high count would exceed 127, address 1 reads 0xFF (127 with bit 7 set).
- R6: A cycle in which no tick pulse arrived is stored with count 0 and valid=0, so a valid period is never zero.
- R7: A read of address 0 clears the valid flag and keeps the count, unless a new period is stored on the same clock, in which case the new result wins.
- R8: While detect_en or raw_mode is low, neither register changes (apart from R7), and the next rising edge after both are high again counts as a first edge.
- R9: rd_data takes the selected register one clock after rd_en is sampled high (rd_addr 0 = period, 1 = high time) and holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_raw | input | 1 | Raw, non-demodulated IR input (asynchronous) |
| tick_2mhz | input | 1 | One-clock pulse at 2 MHz, the 500 ns time base |
| detect_en | input | 1 | Carrier detection enable |
| raw_mode | input | 1 | High when the input path carries the raw carrier |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 1 | Register select: 0 period, 1 high time |
| rd_data | output | 8 | Registered read data |

## Verification
A change on ir_raw reaches the registers three clocks later: two synchronizer flops plus the edge-detect flop. rd_data then follows rd_en by one clock. The bench reference model delays the input by the same three edges and registers its read data on the same edge, and the output is compared against it at every falling clock edge. The explicit value checks read only after the input has been held steady for many clocks, so each expected value is already settled. The zero-count case is timed against the bench's own tick schedule, so that both rising edges fall between two ticks.

// File: rtl/ircm_pkg.sv
package ircm_pkg;

    localparam int CNT_W_DEF   = 7;
    localparam int SYNC_DEF    = 2;

    typedef enum logic {
        SEL_PERIOD = 1'b0,
        SEL_HIGH   = 1'b1
    } rd_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic level;
    } edge_t;

endpackage

// File: rtl/ircm_sync_edge.sv
module ircm_sync_edge
    import ircm_pkg::*;
#(
    parameter int STAGES = SYNC_DEF
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    output edge_t edg
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    always_comb begin
        edg.level = sh[STAGES-1];
        edg.rise  = sh[STAGES-1] & ~sh[STAGES];
        edg.fall  = ~sh[STAGES-1] & sh[STAGES];
    end
endmodule

// File: rtl/ircm_sat_counter.sv
module ircm_sat_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         run,
    input  logic         tick,
    output logic [W-1:0] cnt_nxt,
    output logic         ovf_nxt
);
    logic [W-1:0] cnt;
    logic         ovf;
    logic         step;
    logic         at_max;

    always_comb begin
        step    = run & tick;
        at_max  = &cnt;
        cnt_nxt = (step && !at_max) ? cnt + 1'b1 : cnt;
        ovf_nxt = ovf | (step & at_max);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (run) begin
            cnt <= cnt_nxt;
            ovf <= ovf_nxt;
        end
    end
endmodule

// File: rtl/ircm_result_regs.sv
module ircm_result_regs
    import ircm_pkg::*;
#(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         per_commit,
    input  logic [W-1:0] per_cnt,
    input  logic         per_ok,
    input  logic         hi_commit,
    input  logic [W-1:0] hi_cnt,
    input  logic         hi_sat,
    input  logic         rd_en,
    input  rd_sel_e      rd_sel,
    output logic [W:0]   per_q,
    output logic [W:0]   hi_q,
    output logic [W:0]   rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            per_q   <= '0;
            hi_q    <= '0;
            rd_data <= '0;
        end else begin
            if (per_commit)
                per_q <= {per_ok, per_cnt};
            else if (rd_en && rd_sel == SEL_PERIOD)
                per_q[W] <= 1'b0;

            if (hi_commit)
                hi_q <= {hi_sat, hi_cnt};

            if (rd_en)
                rd_data <= (rd_sel == SEL_HIGH) ? hi_q : per_q;
        end
    end
endmodule

// File: rtl/ircm_meter.sv
module ircm_meter
    import ircm_pkg::*;
#(
    parameter int CNT_W       = CNT_W_DEF,
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ir_raw,
    input  logic           tick_2mhz,
    input  logic           detect_en,
    input  logic           raw_mode,
    input  logic           rd_en,
    input  logic           rd_addr,
    output logic [CNT_W:0] rd_data
);
    edge_t            edg;
    logic             en;
    logic             armed;
    logic             hi_run;
    logic [CNT_W-1:0] per_nxt;
    logic             per_ovf_nxt;
    logic [CNT_W-1:0] hi_nxt;
    logic             hi_ovf_nxt;
    logic             commit;
    logic             per_ok;
    logic             hi_commit;
    logic             cnt_clr;
    logic [CNT_W:0]   per_q;
    logic [CNT_W:0]   hi_q;
    rd_sel_e          rd_sel;

    assign en        = detect_en & raw_mode;
    assign cnt_clr   = ~en | edg.rise;
    assign commit    = en & edg.rise & armed;
    assign per_ok    = ~per_ovf_nxt & (per_nxt != '0);
    assign hi_commit = en & edg.fall & hi_run;
    assign rd_sel    = rd_addr ? SEL_HIGH : SEL_PERIOD;

    ircm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (ir_raw),
        .edg (edg)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            armed  <= 1'b0;
            hi_run <= 1'b0;
        end else if (edg.rise) begin
            armed  <= 1'b1;
            hi_run <= 1'b1;
        end else if (edg.fall) begin
            hi_run <= 1'b0;
        end
    end

    ircm_sat_counter #(.W(CNT_W)) u_per_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (cnt_clr),
        .run     (en),
        .tick    (tick_2mhz),
        .cnt_nxt (per_nxt),
        .ovf_nxt (per_ovf_nxt)
    );

    ircm_sat_counter #(.W(CNT_W)) u_hi_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (cnt_clr),
        .run     (hi_run),
        .tick    (tick_2mhz),
        .cnt_nxt (hi_nxt),
        .ovf_nxt (hi_ovf_nxt)
    );

    ircm_result_regs #(.W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .per_commit (commit),
        .per_cnt    (per_nxt),
        .per_ok     (per_ok),
        .hi_commit  (hi_commit),
        .hi_cnt     (hi_nxt),
        .hi_sat     (hi_ovf_nxt),
        .rd_en      (rd_en),
        .rd_sel     (rd_sel),
        .per_q      (per_q),
        .hi_q       (hi_q),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/ircm_meter_chk.sv
module ircm_meter_chk #(
    parameter int CNT_W = 7
) (
    input logic           clk,
    input logic           rst,
    input logic           en,
    input logic           rise,
    input logic           armed,
    input logic           commit,
    input logic           per_ovf_nxt,
    input logic [CNT_W:0] per_q,
    input logic [CNT_W:0] hi_q,
    input logic           rd_en,
    input logic           rd_addr,
    input logic [CNT_W:0] rd_data
);
    AST_VALID_NONZERO: assert property (@(posedge clk) disable iff (rst)
        per_q[CNT_W] |-> (per_q[CNT_W-1:0] != '0)); // R6

    AST_SAT_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        (commit && per_ovf_nxt) |=> !per_q[CNT_W]); // R5

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_addr && !commit) |=> !per_q[CNT_W]); // R7

    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(per_q[CNT_W-1:0]) && $stable(hi_q))); // R8

    AST_ARM_ONLY: assert property (@(posedge clk) disable iff (rst)
        (rise && !armed) |=> $stable(per_q[CNT_W-1:0])); // R4

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R9
endmodule

bind ircm_meter ircm_meter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .rise        (edg.rise),
    .armed       (armed),
    .commit      (commit),
    .per_ovf_nxt (per_ovf_nxt),
    .per_q       (per_q),
    .hi_q        (hi_q),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data)
);

// File: tb/tb_ircm_meter.sv
`timescale 1ns/1ps
module tb_ircm_meter;
    localparam int TPD = 25;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ir_raw = 1'b0;
    logic       tick_2mhz = 1'b0;
    logic       detect_en = 1'b0;
    logic       raw_mode = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;

    int    checks = 0;
    int    errors = 0;
    int    tcnt = 0;
    bit    done = 0;
    string cur_req = "R1";

    ircm_meter dut (
        .clk(clk), .rst(rst), .ir_raw(ir_raw), .tick_2mhz(tick_2mhz),
        .detect_en(detect_en), .raw_mode(raw_mode),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tcnt      = (tcnt == TPD - 1) ? 0 : tcnt + 1;
        tick_2mhz = (tcnt == 0);
    end

    // behavioural reference model
    bit q1, q2, q3, rise_m, fall_m, e, armed_m, hrun, povf, hovf, pov, hov, nv, val_m;
    int pc, hc, pn, hn, per_m, hi_m, rdq;

    always @(posedge clk) begin
        if (rst) begin
            q1 = 0; q2 = 0; q3 = 0; armed_m = 0; hrun = 0; povf = 0; hovf = 0;
            val_m = 0; pc = 0; hc = 0; per_m = 0; hi_m = 0; rdq = 0;
        end else begin
            rise_m = q2 && !q3;
            fall_m = !q2 && q3;
            e = detect_en && raw_mode;
            if (rd_en) rdq = rd_addr ? hi_m : (val_m * 128 + per_m);
            pn = pc + ((e && tick_2mhz) ? 1 : 0); pov = povf;
            if (pn > 127) begin pn = 127; pov = 1; end
            hn = hc + ((hrun && tick_2mhz) ? 1 : 0); hov = hovf;
            if (hn > 127) begin hn = 127; hov = 1; end
            nv = val_m;
            if (rd_en && !rd_addr) nv = 0;
            if (!e) begin
                pc = 0; povf = 0; hc = 0; hovf = 0; hrun = 0; armed_m = 0;
            end else if (rise_m) begin
                if (armed_m) begin per_m = pn; nv = (!pov && pn != 0); end
                armed_m = 1; pc = 0; povf = 0; hc = 0; hovf = 0; hrun = 1;
            end else begin
                pc = pn; povf = pov;
                if (hrun) begin
                    hc = hn; hovf = hov;
                    if (fall_m) begin hi_m = hov * 128 + hn; hrun = 0; end
                end
            end
            val_m = nv;
            q3 = q2; q2 = q1; q1 = ir_raw;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (rd_data !== rdq[7:0]) begin
                errors++;
                $display("FAIL %s: model compare rd_data=%02h expected=%02h at %0t",
                         cur_req, rd_data, rdq[7:0], $time);
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic send_cycle(input int hi_t, input int lo_t);
        ir_raw = 1'b1;
        repeat (hi_t * TPD) @(negedge clk);
        ir_raw = 1'b0;
        repeat (lo_t * TPD) @(negedge clk);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        cur_req = "R1";
        rd(1'b0, d); chk("R1", d, 8'h00);
        rd(1'b1, d); chk("R1", d, 8'h00);

        cur_req = "R8";
        raw_mode = 1'b1; detect_en = 1'b0;
        repeat (3) send_cycle(10, 10);
        settle();
        rd(1'b0, d); chk("R8", d, 8'h00);
        raw_mode = 1'b0; detect_en = 1'b1;
        repeat (3) send_cycle(10, 10);
        settle();
        rd(1'b1, d); chk("R8", d, 8'h00);

        cur_req = "R4";
        raw_mode = 1'b1;
        repeat (20) @(negedge clk);
        send_cycle(26, 26);
        settle();
        rd(1'b0, d); chk("R4", d, 8'h00);
        rd(1'b1, d); chk("R3", d, 8'h1A);
        cur_req = "R2";
        send_cycle(26, 26);
        send_cycle(26, 26);
        settle();
        rd(1'b0, d); chk("R2", d, 8'hB4);
        cur_req = "R7";
        rd(1'b0, d); chk("R7", d, 8'h34);

        cur_req = "R3";
        repeat (3) send_cycle(5, 15);
        settle();
        rd(1'b0, d); chk("R2", d, 8'h94);
        rd(1'b1, d); chk("R3", d, 8'h05);

        cur_req = "R8";
        repeat (2) send_cycle(5, 5);
        settle();
        detect_en = 1'b0;
        repeat (3) send_cycle(12, 18);
        settle();
        rd(1'b1, d); chk("R8", d, 8'h05);
        rd(1'b0, d); chk("R8", d, 8'h8A);
        detect_en = 1'b1;
        cur_req = "R4";
        send_cycle(12, 18);
        settle();
        rd(1'b0, d); chk("R4", d, 8'h0A);
        send_cycle(12, 18);
        settle();
        rd(1'b0, d); chk("R2", d, 8'h9E);

        cur_req = "R5";
        send_cycle(130, 20);
        settle();
        rd(1'b1, d); chk("R5", d, 8'hFF);
        ir_raw = 1'b1;
        settle();
        rd(1'b0, d); chk("R5", d, 8'h7F);
        repeat (20) @(negedge clk);
        ir_raw = 1'b0;
        repeat (40) @(negedge clk);

        cur_req = "R6";
        @(posedge clk);
        while (tick_2mhz !== 1'b1) @(posedge clk);
        @(negedge clk);
        ir_raw = 1'b1; repeat (4) @(negedge clk);
        ir_raw = 1'b0; repeat (4) @(negedge clk);
        ir_raw = 1'b1;
        settle();
        rd(1'b0, d); chk("R6", d, 8'h00);
        rd(1'b1, d); chk("R6", d, 8'h00);
        ir_raw = 1'b0;

        cur_req = "R9";
        repeat (10) @(negedge clk);
        rd(1'b1, d); chk("R9", d, 8'h00);
        repeat (5) @(negedge clk);
        chk("R9", rd_data, 8'h00);

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            finish_run();
        end
    end
endmodule